// File: doc/BRIEF.md
# 16-bit ALU with Flag Register

This block performs the data operations of a small byte-coded processor. Each operation names one opcode byte and supplies two 16-bit operands: the first is the destination register's current value, and the second is a source register value or a 16-bit immediate. The block also receives the current flag register. It returns the 16-bit result, the updated flag register, a write-enable for the destination register, a divide-by-zero trap and an invalid-opcode indication. The surrounding core reads the register file, fetches instructions and accesses memory. This block does none of those things.

An operation is issued by pulsing `start` while `busy` is low. Most operations finish one clock later. Signed multiply and signed divide use a bit-serial datapath and finish later. Completion is marked by a one-cycle `done` strobe. Every result output holds its value until the next completion. Flag updates depend on the class of the opcode. Carry is set only by shifts and rotates. Overflow is set only by arithmetic and logic operations. Zero and sign follow every result except a plain move.

Top module: `alu16_flags`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `busy`, `wr_en`, `div_zero`, `bad_op`, `result` and `flags_out` are all zero until the first operation completes.
- R2: MOV (0x16) and MOVI (0x30) return the second operand with `wr_en` high. The flags pass through unchanged, with unused bits cleared. `done` rises on the first clock edge after `start` is accepted, and this one-edge latency applies to every opcode except a multiply or divide with a nonzero divisor.
- R3: ADD 0x17/0x31, SUB 0x18/0x32, INC 0x75 (a+1) and DEC 0x76 (a-1) return the 16-bit wrapped result. Overflow is set exactly when the carry into bit 15 differs from the carry out of bit 15. Carry keeps its old value.
- R4: AND 0x1B/0x35 and OR 0x1C/0x36 are bitwise operations. They clear overflow and keep carry unchanged.
- R5: Every arithmetic, logic, shift and rotate operation sets zero when the result is 0 and sets sign equal to bit 15 of the result.
- R6: SHL 0x71 and SHR 0x72 shift by one bit and fill with 0. RTL 0x73 and RTR 0x74 rotate by one bit, and the bit that leaves re-enters at the other end. All four set carry to bit 15 of the operand before the operation and keep overflow unchanged.
- R7: MUL 0x19/0x33 returns the low 16 bits of the signed product. Overflow is set when the full product lies outside -32768..32767, and carry is kept. `done` rises 18 clock edges after acceptance, counting the accepting edge.
- R8: DIV 0x1A/0x34 with a nonzero divisor returns the signed quotient, truncated toward zero. Overflow is set only for -32768 / -1, which returns 0x8000. Carry is kept. The latency is 18 edges.
- R9: A divide whose second operand is 0 raises `div_zero` with `done`. It leaves `wr_en` low, `result` zero and the flags unchanged.
- R10: Any opcode outside the set above raises `bad_op` with `done`. It leaves `wr_en` low, `result` zero and the flags unchanged. Every completion raises exactly one of `wr_en`, `div_zero` and `bad_op`.
- R11: While `busy` is high, `start` is ignored. The operation in flight completes exactly once, with its own result.
- R12: The flag register bit positions are carry at bit 1, zero at bit 2, sign at bit 3 and overflow at bit 4. All other bits of `flags_out` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue the operation on the current inputs |
| opcode | input | 8 | Operation byte |
| opa | input | 16 | First operand (destination register value) |
| opb | input | 16 | Second operand (source register or immediate) |
| flags_in | input | 16 | Current flag register |
| busy | output | 1 | A multiply or divide is in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Value to write to the destination |
| flags_out | output | 16 | Updated flag register |
| wr_en | output | 1 | Write `result` to the destination |
| div_zero | output | 1 | Divide-by-zero trap |
| bad_op | output | 1 | Unsupported opcode |

## Verification
Single-step operations, a zero-divisor divide and an invalid opcode all complete on the first edge after `start` is accepted. A multiply or a divide with a nonzero divisor completes on the eighteenth edge. The bench changes inputs on falling edges. It counts falling edges from the one that follows the accepting edge until `done` is seen, then compares the measured latency with the required value and reads `result`, `flags_out` and the three status outputs in that same half-cycle. The busy test injects a second `start` partway through a multiply. It then watches thirty cycles to confirm that only one completion arrives, at the expected edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Opcode bytes, register and immediate forms.
    localparam logic [7:0] OPC_MOV  = 8'h16;
    localparam logic [7:0] OPC_ADD  = 8'h17;
    localparam logic [7:0] OPC_SUB  = 8'h18;
    localparam logic [7:0] OPC_MUL  = 8'h19;
    localparam logic [7:0] OPC_DIV  = 8'h1A;
    localparam logic [7:0] OPC_AND  = 8'h1B;
    localparam logic [7:0] OPC_OR   = 8'h1C;
    localparam logic [7:0] OPC_MOVI = 8'h30;
    localparam logic [7:0] OPC_ADDI = 8'h31;
    localparam logic [7:0] OPC_SUBI = 8'h32;
    localparam logic [7:0] OPC_MULI = 8'h33;
    localparam logic [7:0] OPC_DIVI = 8'h34;
    localparam logic [7:0] OPC_ANDI = 8'h35;
    localparam logic [7:0] OPC_ORI  = 8'h36;
    localparam logic [7:0] OPC_SHL  = 8'h71;
    localparam logic [7:0] OPC_SHR  = 8'h72;
    localparam logic [7:0] OPC_ROL  = 8'h73;
    localparam logic [7:0] OPC_ROR  = 8'h74;
    localparam logic [7:0] OPC_INC  = 8'h75;
    localparam logic [7:0] OPC_DEC  = 8'h76;

    // Flag register bit positions.
    localparam int FLG_C = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_S = 3;
    localparam int FLG_V = 4;

    typedef enum logic [3:0] {
        FN_BAD, FN_MOV, FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_AND,
        FN_OR, FN_SHL, FN_SHR, FN_ROL, FN_ROR, FN_INC, FN_DEC
    } alu_fn_t;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;

    typedef struct packed {
        logic wr;
        logic dz;
        logic bad;
    } alu_stat_t;

    function automatic alu_fn_t decode_op(input logic [7:0] opc);
        case (opc)
            OPC_MOV, OPC_MOVI: return FN_MOV;
            OPC_ADD, OPC_ADDI: return FN_ADD;
            OPC_SUB, OPC_SUBI: return FN_SUB;
            OPC_MUL, OPC_MULI: return FN_MUL;
            OPC_DIV, OPC_DIVI: return FN_DIV;
            OPC_AND, OPC_ANDI: return FN_AND;
            OPC_OR,  OPC_ORI:  return FN_OR;
            OPC_SHL:           return FN_SHL;
            OPC_SHR:           return FN_SHR;
            OPC_ROL:           return FN_ROL;
            OPC_ROR:           return FN_ROR;
            OPC_INC:           return FN_INC;
            OPC_DEC:           return FN_DEC;
            default:           return FN_BAD;
        endcase
    endfunction

endpackage

// File: rtl/alu_onecycle.sv
module alu_onecycle
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_t             fn,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   fin,
    output logic [DATA_W-1:0]   res,
    output logic [DATA_W-1:0]   fout,
    output alu_stat_t           stat
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] FMASK = (DATA_W'(1) << FLG_C) | (DATA_W'(1) << FLG_Z)
                                        | (DATA_W'(1) << FLG_S) | (DATA_W'(1) << FLG_V);

    logic [DATA_W-1:0] add_b;
    logic              add_ci;
    logic [DATA_W-1:0] add_low;
    logic [DATA_W:0]   add_full;
    logic              zs_upd, c_upd, c_new, v_upd, v_new;

    // Shared adder: the low part exposes the carry into the top bit.
    always_comb begin
        add_b  = b;
        add_ci = 1'b0;
        case (fn)
            FN_SUB:  begin add_b = ~b; add_ci = 1'b1; end
            FN_INC:  add_b = DATA_W'(1);
            FN_DEC:  add_b = '1;
            default: ;
        endcase
        add_low  = {1'b0, a[MSB-1:0]} + {1'b0, add_b[MSB-1:0]} + DATA_W'(add_ci);
        add_full = {1'b0, a} + {1'b0, add_b} + (DATA_W+1)'(add_ci);
    end

    always_comb begin
        res    = '0;
        fout   = fin & FMASK;
        stat   = '0;
        zs_upd = 1'b0;
        c_upd  = 1'b0;
        c_new  = 1'b0;
        v_upd  = 1'b0;
        v_new  = 1'b0;
        case (fn)
            FN_MOV: begin
                res     = b;
                stat.wr = 1'b1;
            end
            FN_ADD, FN_SUB, FN_INC, FN_DEC: begin
                res     = add_full[MSB:0];
                v_upd   = 1'b1;
                v_new   = add_low[MSB] ^ add_full[DATA_W];
                zs_upd  = 1'b1;
                stat.wr = 1'b1;
            end
            FN_AND, FN_OR: begin
                res     = (fn == FN_AND) ? (a & b) : (a | b);
                v_upd   = 1'b1;
                zs_upd  = 1'b1;
                stat.wr = 1'b1;
            end
            FN_SHL, FN_SHR, FN_ROL, FN_ROR: begin
                case (fn)
                    FN_SHL:  res = {a[MSB-1:0], 1'b0};
                    FN_SHR:  res = {1'b0, a[MSB:1]};
                    FN_ROL:  res = {a[MSB-1:0], a[MSB]};
                    default: res = {a[0], a[MSB:1]};
                endcase
                c_upd   = 1'b1;
                c_new   = a[MSB];
                zs_upd  = 1'b1;
                stat.wr = 1'b1;
            end
            FN_DIV:  stat.dz  = (b == '0);
            FN_MUL:  ;
            default: stat.bad = 1'b1;
        endcase
        if (zs_upd) begin
            fout[FLG_Z] = (res == '0);
            fout[FLG_S] = res[MSB];
        end
        if (c_upd) fout[FLG_C] = c_new;
        if (v_upd) fout[FLG_V] = v_new;
    end

endmodule

// File: rtl/alu_mul_seq.sv
module alu_mul_seq #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              fin,
    output logic [DATA_W-1:0] prod,
    output logic              ovf
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam int PW = 2 * DATA_W;
    localparam logic [PW-1:0] POS_MAX = {(DATA_W+1)'(0), {(DATA_W-1){1'b1}}};
    localparam logic [PW-1:0] NEG_MAG = POS_MAX + PW'(1);

    logic          busy_q, neg_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] acc_q, mcand_q;
    logic [DATA_W-1:0] mplier_q;
    logic [PW-1:0] full;

    function automatic logic [DATA_W-1:0] mag(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + DATA_W'(1)) : v;
    endfunction

    // Shift-and-add on operand magnitudes, sign applied at the end.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            neg_q    <= 1'b0;
            cnt_q    <= '0;
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (go) begin
            busy_q   <= 1'b1;
            neg_q    <= a[DATA_W-1] ^ b[DATA_W-1];
            cnt_q    <= CW'(DATA_W);
            acc_q    <= '0;
            mcand_q  <= {{DATA_W{1'b0}}, mag(a)};
            mplier_q <= mag(b);
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                if (mplier_q[0]) acc_q <= acc_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - CW'(1);
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign fin  = busy_q && (cnt_q == '0);
    assign full = neg_q ? (~acc_q + PW'(1)) : acc_q;
    assign prod = full[DATA_W-1:0];
    assign ovf  = neg_q ? (acc_q > NEG_MAG) : (acc_q > POS_MAX);

endmodule

// File: rtl/alu_div_seq.sv
module alu_div_seq #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              fin,
    output logic [DATA_W-1:0] quot,
    output logic              ovf
);
    localparam int CW  = $clog2(DATA_W + 1);
    localparam int MSB = DATA_W - 1;

    logic              busy_q, neg_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] rem_q, quo_q, dvsr_q;
    logic [DATA_W:0]   rsh, diff;

    function automatic logic [DATA_W-1:0] mag(input logic [DATA_W-1:0] v);
        return v[MSB] ? (~v + DATA_W'(1)) : v;
    endfunction

    assign rsh  = {rem_q, quo_q[MSB]};
    assign diff = rsh - {1'b0, dvsr_q};

    // Restoring division on magnitudes; truncation toward zero follows.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            neg_q  <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            neg_q  <= a[MSB] ^ b[MSB];
            cnt_q  <= CW'(DATA_W);
            rem_q  <= '0;
            quo_q  <= mag(a);
            dvsr_q <= mag(b);
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                if (!diff[DATA_W]) begin
                    rem_q <= diff[MSB:0];
                    quo_q <= {quo_q[MSB-1:0], 1'b1};
                end else begin
                    rem_q <= rsh[MSB:0];
                    quo_q <= {quo_q[MSB-1:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign fin  = busy_q && (cnt_q == '0);
    assign quot = neg_q ? (~quo_q + DATA_W'(1)) : quo_q;
    assign ovf  = !neg_q && quo_q[MSB];

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] flags_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags_out,
    output logic              wr_en,
    output logic              div_zero,
    output logic              bad_op
);
    localparam logic [DATA_W-1:0] FMASK = (DATA_W'(1) << FLG_C) | (DATA_W'(1) << FLG_Z)
                                        | (DATA_W'(1) << FLG_S) | (DATA_W'(1) << FLG_V);

    seq_state_t        state_q;
    alu_fn_t           fn, fn_q;
    logic [DATA_W-1:0] fkeep_q;
    logic [DATA_W-1:0] sc_res, sc_flags;
    alu_stat_t         sc_stat;
    logic              accept, long_op, mul_go, div_go;
    logic              mul_fin, div_fin, mul_ovf, div_ovf;
    logic [DATA_W-1:0] mul_res, div_res;
    logic              l_fin, l_ovf;
    logic [DATA_W-1:0] l_res, l_flags;

    assign fn      = decode_op(opcode);
    assign accept  = start && (state_q == ST_IDLE);
    assign long_op = (fn == FN_MUL) || ((fn == FN_DIV) && (opb != '0));
    assign mul_go  = accept && (fn == FN_MUL);
    assign div_go  = accept && long_op && (fn == FN_DIV);

    alu_onecycle #(.DATA_W(DATA_W)) u_single (
        .fn   (fn),
        .a    (opa),
        .b    (opb),
        .fin  (flags_in),
        .res  (sc_res),
        .fout (sc_flags),
        .stat (sc_stat)
    );

    alu_mul_seq #(.DATA_W(DATA_W)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (mul_go),
        .a    (opa),
        .b    (opb),
        .fin  (mul_fin),
        .prod (mul_res),
        .ovf  (mul_ovf)
    );

    alu_div_seq #(.DATA_W(DATA_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .a    (opa),
        .b    (opb),
        .fin  (div_fin),
        .quot (div_res),
        .ovf  (div_ovf)
    );

    assign l_fin = (fn_q == FN_MUL) ? mul_fin : div_fin;
    assign l_res = (fn_q == FN_MUL) ? mul_res : div_res;
    assign l_ovf = (fn_q == FN_MUL) ? mul_ovf : div_ovf;

    always_comb begin
        l_flags        = fkeep_q;
        l_flags[FLG_Z] = (l_res == '0);
        l_flags[FLG_S] = l_res[DATA_W-1];
        l_flags[FLG_V] = l_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fn_q      <= FN_BAD;
            fkeep_q   <= '0;
            done      <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            wr_en     <= 1'b0;
            div_zero  <= 1'b0;
            bad_op    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (long_op) begin
                    state_q <= ST_WAIT;
                    fn_q    <= fn;
                    fkeep_q <= flags_in & FMASK;
                end else begin
                    done      <= 1'b1;
                    result    <= sc_res;
                    flags_out <= sc_flags;
                    wr_en     <= sc_stat.wr;
                    div_zero  <= sc_stat.dz;
                    bad_op    <= sc_stat.bad;
                end
            end else if (state_q == ST_WAIT && l_fin) begin
                state_q   <= ST_IDLE;
                done      <= 1'b1;
                result    <= l_res;
                flags_out <= l_flags;
                wr_en     <= 1'b1;
                div_zero  <= 1'b0;
                bad_op    <= 1'b0;
            end
        end
    end

    assign busy = (state_q == ST_WAIT);

endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] opb,
    input logic [DATA_W-1:0] flags_in,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] flags_out,
    input logic              wr_en,
    input logic              div_zero,
    input logic              bad_op
);
    localparam logic [DATA_W-1:0] USED = DATA_W'(16'h001E);

    // R10: each completion has exactly one outcome
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({wr_en, div_zero, bad_op}) == 1));

    // R12: unused flag bits stay zero
    assert_unused_flags_R12: assert property (@(posedge clk) disable iff (rst)
        (flags_out & ~USED) == '0);

    // R2: moves pass flags through and write
    assert_move_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (opcode == 8'h16 || opcode == 8'h30))
        |=> (done && wr_en && flags_out == ($past(flags_in) & USED)));

    // R3: add keeps the carry flag
    assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (opcode == 8'h17 || opcode == 8'h31))
        |=> (flags_out[1] == $past(flags_in[1])));

    // R9: zero divisor traps on the next edge without a write
    assert_div_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (opcode == 8'h1A || opcode == 8'h34) && opb == '0)
        |=> (done && div_zero && !wr_en && result == '0));

    // R7: a multiply holds the unit busy without completing at once
    assert_mul_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (opcode == 8'h19 || opcode == 8'h33))
        |=> (busy && !done));

    // R11: completion always returns the unit to idle
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind alu16_flags alu16_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opcode    (opcode),
    .opb       (opb),
    .flags_in  (flags_in),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en),
    .div_zero  (div_zero),
    .bad_op    (bad_op)
);

// File: tb/alu16_flags_test.sv
module alu16_flags_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] opa = '0, opb = '0, flags_in = '0;
    logic        busy, done, wr_en, div_zero, bad_op;
    logic [15:0] result, flags_out;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    alu16_flags uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .opa(opa), .opb(opb),
        .flags_in(flags_in), .busy(busy), .done(done), .result(result),
        .flags_out(flags_out), .wr_en(wr_en), .div_zero(div_zero), .bad_op(bad_op)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] fi;
        logic [15:0] res;
        logic [15:0] fo;
        logic        wr;
        logic        dz;
        logic        bad;
        logic [7:0]  lat;
        logic [7:0]  req;
    } vec_t;

    // Flag bits: C=0x0002 Z=0x0004 S=0x0008 V=0x0010 (R12)
    localparam int NV = 31;
    localparam vec_t VT [NV] = '{
        '{8'h16, 16'h1234, 16'hBEEF, 16'hFFFF, 16'hBEEF, 16'h001E, 1'b1, 1'b0, 1'b0, 8'd1,  8'd2},  // R2 R12
        '{8'h30, 16'h5555, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 8'd1,  8'd2},  // R2
        '{8'h17, 16'h7FFF, 16'h0001, 16'h0002, 16'h8000, 16'h001A, 1'b1, 1'b0, 1'b0, 8'd1,  8'd3},  // R3
        '{8'h31, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 16'h0004, 1'b1, 1'b0, 1'b0, 8'd1,  8'd5},  // R5
        '{8'h18, 16'h8000, 16'h0001, 16'h0000, 16'h7FFF, 16'h0010, 1'b1, 1'b0, 1'b0, 8'd1,  8'd3},  // R3
        '{8'h32, 16'h0005, 16'h0007, 16'h0010, 16'hFFFE, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd1,  8'd3},  // R3
        '{8'h75, 16'h7FFF, 16'h1234, 16'h0002, 16'h8000, 16'h001A, 1'b1, 1'b0, 1'b0, 8'd1,  8'd3},  // R3
        '{8'h76, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 1'b1, 1'b0, 1'b0, 8'd1,  8'd5},  // R5
        '{8'h1B, 16'hF0F0, 16'h0FF0, 16'h0012, 16'h00F0, 16'h0002, 1'b1, 1'b0, 1'b0, 8'd1,  8'd4},  // R4
        '{8'h36, 16'h8000, 16'h0001, 16'h0000, 16'h8001, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd1,  8'd4},  // R4
        '{8'h35, 16'h00FF, 16'hFF00, 16'h0000, 16'h0000, 16'h0004, 1'b1, 1'b0, 1'b0, 8'd1,  8'd4},  // R4
        '{8'h1C, 16'h0000, 16'h0000, 16'h0010, 16'h0000, 16'h0004, 1'b1, 1'b0, 1'b0, 8'd1,  8'd4},  // R4
        '{8'h71, 16'h8001, 16'h0000, 16'h0010, 16'h0002, 16'h0012, 1'b1, 1'b0, 1'b0, 8'd1,  8'd6},  // R6
        '{8'h72, 16'h8001, 16'h0000, 16'h0000, 16'h4000, 16'h0002, 1'b1, 1'b0, 1'b0, 8'd1,  8'd6},  // R6
        '{8'h73, 16'h8001, 16'h0000, 16'h0000, 16'h0003, 16'h0002, 1'b1, 1'b0, 1'b0, 8'd1,  8'd6},  // R6
        '{8'h74, 16'h0001, 16'h0000, 16'h0002, 16'h8000, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd1,  8'd6},  // R6
        '{8'h71, 16'h4000, 16'h0000, 16'h0000, 16'h8000, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd1,  8'd6},  // R6
        '{8'h72, 16'h0001, 16'h0000, 16'h0002, 16'h0000, 16'h0004, 1'b1, 1'b0, 1'b0, 8'd1,  8'd6},  // R6
        '{8'h19, 16'hFFFD, 16'h0007, 16'h0000, 16'hFFEB, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd18, 8'd7},  // R7
        '{8'h33, 16'h0100, 16'h0100, 16'h0002, 16'h0000, 16'h0016, 1'b1, 1'b0, 1'b0, 8'd18, 8'd7},  // R7
        '{8'h19, 16'h8000, 16'h0001, 16'h0000, 16'h8000, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd18, 8'd7},  // R7
        '{8'h19, 16'hFF00, 16'h0080, 16'h0000, 16'h8000, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd18, 8'd7},  // R7
        '{8'h1A, 16'hFFF9, 16'h0002, 16'h0000, 16'hFFFD, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd18, 8'd8},  // R8
        '{8'h34, 16'h0007, 16'hFFFE, 16'h0000, 16'hFFFD, 16'h0008, 1'b1, 1'b0, 1'b0, 8'd18, 8'd8},  // R8
        '{8'h1A, 16'h8000, 16'hFFFF, 16'h0000, 16'h8000, 16'h0018, 1'b1, 1'b0, 1'b0, 8'd18, 8'd8},  // R8
        '{8'h1A, 16'h0003, 16'h0005, 16'h0002, 16'h0000, 16'h0006, 1'b1, 1'b0, 1'b0, 8'd18, 8'd8},  // R8
        '{8'h1A, 16'h0064, 16'h0000, 16'h0008, 16'h0000, 16'h0008, 1'b0, 1'b1, 1'b0, 8'd1,  8'd9},  // R9
        '{8'h34, 16'h0000, 16'h0000, 16'hFFE1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 8'd1,  8'd9},  // R9
        '{8'h20, 16'h1111, 16'h2222, 16'h0014, 16'h0000, 16'h0014, 1'b0, 1'b0, 1'b1, 8'd1,  8'd10}, // R10
        '{8'h3D, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 8'd1,  8'd10}, // R10
        '{8'hF2, 16'hAAAA, 16'h0000, 16'h0006, 16'h0000, 16'h0006, 1'b0, 1'b0, 1'b1, 8'd1,  8'd10}  // R10
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] fi, output int lat);
        @(negedge clk);
        opcode = op; opa = a; opb = b; flags_in = fi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat;
        int ndone;
        int first;
        logic [15:0] cap_res;
        logic [15:0] cap_flg;
        string rq;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({done, busy, wr_en, div_zero, bad_op} == 5'b0, "R1", "status in reset",
            32'({done, busy, wr_en, div_zero, bad_op}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(result == 16'h0 && flags_out == 16'h0, "R1", "outputs after reset",
            {result, flags_out}, 32'h0);
        chk(!done && !busy, "R1", "idle after reset", 32'({done, busy}), 32'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(VT[i].op, VT[i].a, VT[i].b, VT[i].fi, lat);
            rq = $sformatf("R%0d op %h", VT[i].req, VT[i].op);
            chk(lat == int'(VT[i].lat), rq, "latency", 32'(lat), 32'(VT[i].lat));
            chk(result == VT[i].res, rq, "result", 32'(result), 32'(VT[i].res));
            chk(flags_out == VT[i].fo, rq, "flags", 32'(flags_out), 32'(VT[i].fo));
            chk({wr_en, div_zero, bad_op} == {VT[i].wr, VT[i].dz, VT[i].bad}, rq, "status",
                32'({wr_en, div_zero, bad_op}), 32'({VT[i].wr, VT[i].dz, VT[i].bad}));
        end

        // R11: a start during a multiply is ignored
        @(negedge clk);
        opcode = 8'h19; opa = 16'h0003; opb = 16'h0004; flags_in = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0; first = 0; cap_res = '0; cap_flg = '0;
        chk(busy, "R11", "busy after multiply accepted", 32'(busy), 32'h1);
        for (int k = 1; k <= 30; k++) begin
            if (done) begin
                ndone++;
                if (first == 0) begin
                    first = k; cap_res = result; cap_flg = flags_out;
                end
            end
            start = (k == 3);
            if (k == 3) begin
                opcode = 8'h17; opa = 16'h0001; opb = 16'h0001; flags_in = 16'h0010;
            end
            @(negedge clk);
        end
        chk(ndone == 1, "R11", "completions", 32'(ndone), 32'h1);
        chk(first == 18, "R11", "completion edge", 32'(first), 32'd18);
        chk(cap_res == 16'h000C, "R11", "result of first op", 32'(cap_res), 32'h000C);
        chk(cap_flg == 16'h0000, "R11", "flags of first op", 32'(cap_flg), 32'h0);
        chk(!busy, "R11", "idle afterwards", 32'(busy), 32'h0);

        // R12: unused flag bits cleared on a shift with all-ones input flags
        run_op(8'h72, 16'h0002, 16'h0000, 16'hFFFF, lat);
        chk(flags_out == 16'h0010 && result == 16'h0001, "R12", "shift flags",
            {result, flags_out}, 32'h00010010);

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog expired before the bench completed");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule